// File: doc/BRIEF.md
# Serial Transceiver Interrupt Mask Unit

This unit sits beside a serial transceiver and its two DMA channels. It turns their one-cycle event pulses into sticky pending flags and gates each flag with a software-controlled enable. It drives one level-sensitive interrupt request, which stays high while any enabled flag remains set. Software reaches two 8-bit registers through a plain write strobe and a select line. One is the enable register, which also holds the two DMA end-of-block flags and the transmit-empty source select. The other is the pending-status register.

Software clears a flag by writing 0 to its bit. Writing 1 leaves the bit unchanged. A hardware set in the same cycle as a software clear takes precedence. The unit also passes the receive-data and selected transmit-empty flags to the DMA engine as request lines. No interrupt enable acts on these lines.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `irq` is low and both DMA request lines are low.
- R2: A pulse on an event input sets its pending-status bit at the next clock edge, and the bit stays set until software clears it. Status bit positions: 0 transmit buffer empty, 1 transmit shift register empty, 2 receive data ready, 3 break, 4 address match, 5 overrun, 6 parity error, 7 framing error.
- R3: A write with `reg_sel`=1 clears each status bit written as 0 and leaves each bit written as 1 unchanged.
- R4: In the enable register (`reg_sel`=0), bit 6 is the receive end-of-block flag and bit 5 is the transmit end-of-block flag. Each is set by its DMA pulse and cleared only by writing 0; writing 1 to them has no effect. Bits 7 and 4..0 take the written value.
- R5: When an event pulse and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: Enable bit 4 gates the overrun, parity and framing flags. Bit 3 gates the address flag, and bit 2 gates the break flag.
- R7: Enable bit 1 gates both the receive-data flag and the receive end-of-block flag.
- R8: Enable bit 0 gates the transmit end-of-block flag and one transmit-empty flag. Bit 7 selects which: 1 selects buffer empty and 0 selects shift register empty. The unselected empty flag never raises `irq`.
- R9: `irq` is the OR of all enabled flags, registered. It changes one clock edge after the flags it reflects.
- R10: `rx_dma_req` follows the receive-data flag and `tx_dma_req` follows the selected transmit-empty flag, whatever the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_rx_data | input | 1 | Receive data ready pulse |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_rx_parity | input | 1 | Receive parity error pulse |
| ev_rx_frame | input | 1 | Receive framing error pulse |
| ev_rx_addr | input | 1 | Receive address match pulse |
| ev_rx_break | input | 1 | Receive break pulse |
| ev_tx_buf_empty | input | 1 | Transmit buffer empty pulse |
| ev_tx_shift_empty | input | 1 | Transmit shift register empty pulse |
| ev_rx_eob | input | 1 | Receive DMA end-of-block pulse |
| ev_tx_eob | input | 1 | Transmit DMA end-of-block pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 enable register, 1 status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Level interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the unit with `IRQ_REG`=1 and a two-stage reset synchronizer. This makes the one-edge lag between a flag change and `irq` observable and checkable. A model inside the bench holds the previous flag state to predict that lag. The lag brings into reach the cycle where an event pulse and a clearing write coincide, and the cycle where only the unselected transmit-empty source is active.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int REG_W = 8;
  // status bit positions
  localparam int ST_TXBUF = 0;
  localparam int ST_TXSHF = 1;
  localparam int ST_RXDAT = 2;
  localparam int ST_BRK   = 3;
  localparam int ST_ADR   = 4;
  localparam int ST_OVR   = 5;
  localparam int ST_PAR   = 6;
  localparam int ST_FRM   = 7;
  // enable register bit positions
  localparam int EN_TX    = 0;
  localparam int EN_RX    = 1;
  localparam int EN_BRK   = 2;
  localparam int EN_ADR   = 3;
  localparam int EN_ERR   = 4;
  localparam int EN_TXEOB = 5;
  localparam int EN_RXEOB = 6;
  localparam int EN_BSEL  = 7;
  localparam int NUM_LANES = 5;
  typedef enum logic {SEL_MASK = 1'b0, SEL_STAT = 1'b1} reg_sel_e;
endpackage

// File: rtl/sio_irq_rstsync.sv
module sio_irq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sio_irq_sticky.sv
module sio_irq_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flags_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q, bit_d, clr, upd;

    always_comb begin
      clr   = wr_i & ~wdata_i[i];
      upd   = set_i[i] | clr;
      bit_d = set_i[i] | (bit_q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  bit_q <= 1'b0;
      else if (upd) bit_q <= bit_d;
    end

    assign flags_o[i] = bit_q;
  end

  // R5: a set pulse always lands, even under a clearing write
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R2: without a write, no flag drops
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R3: bits written as 1 keep their value
  a_r3_ones_keep: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_i |=> ((flags_o & $past(flags_o & wdata_i)) == $past(flags_o & wdata_i)));
endmodule

// File: rtl/sio_irq_maskreg.sv
module sio_irq_maskreg
  import sio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rx_eob_i,
  input  logic             tx_eob_i,
  output logic [REG_W-1:0] mask_o
);
  localparam int CTRL_W = REG_W - 2;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d, ctrl_wval;
  logic [1:0]        eob_flags;

  always_comb begin
    ctrl_wval = {wdata_i[EN_BSEL], wdata_i[EN_ERR:EN_TX]};
    ctrl_d    = wr_i ? ctrl_wval : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_d;
  end

  // [1] = receive end-of-block, [0] = transmit end-of-block
  sio_irq_sticky #(.W(2)) u_eob (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .set_i   ({rx_eob_i, tx_eob_i}),
    .wr_i    (wr_i),
    .wdata_i ({wdata_i[EN_RXEOB], wdata_i[EN_TXEOB]}),
    .flags_o (eob_flags)
  );

  always_comb begin
    mask_o              = '0;
    mask_o[EN_BSEL]     = ctrl_q[CTRL_W-1];
    mask_o[EN_RXEOB]    = eob_flags[1];
    mask_o[EN_TXEOB]    = eob_flags[0];
    mask_o[EN_ERR:EN_TX] = ctrl_q[CTRL_W-2:0];
  end

  // R4: enable bits take the written value at the next edge
  a_r4_ctrl_follows: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_i |=> ({mask_o[EN_BSEL], mask_o[EN_ERR:EN_TX]} ==
              $past({wdata_i[EN_BSEL], wdata_i[EN_ERR:EN_TX]})));
endmodule

// File: rtl/sio_irq_gate.sv
module sio_irq_gate
  import sio_irq_pkg::*;
#(
  parameter bit IRQ_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] mask_i,
  input  logic [REG_W-1:0] stat_i,
  output logic             irq_o,
  output logic             rx_dma_o,
  output logic             tx_dma_o
);
  logic                 tx_src;
  logic [NUM_LANES-1:0] lane_req, lane_en;
  logic                 hit;

  always_comb begin
    tx_src = mask_i[EN_BSEL] ? stat_i[ST_TXBUF] : stat_i[ST_TXSHF];
    lane_req[EN_TX]  = tx_src | mask_i[EN_TXEOB];
    lane_req[EN_RX]  = stat_i[ST_RXDAT] | mask_i[EN_RXEOB];
    lane_req[EN_BRK] = stat_i[ST_BRK];
    lane_req[EN_ADR] = stat_i[ST_ADR];
    lane_req[EN_ERR] = stat_i[ST_OVR] | stat_i[ST_PAR] | stat_i[ST_FRM];
    lane_en          = mask_i[NUM_LANES-1:0];
    hit              = |(lane_req & lane_en);
  end

  assign rx_dma_o = stat_i[ST_RXDAT];
  assign tx_dma_o = tx_src;

  if (IRQ_REG) begin : g_reg
    logic irq_q, irq_d;
    always_comb irq_d = hit;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= irq_d;
    end
    assign irq_o = irq_q;

    // R9: request follows the enabled sources one edge later
    a_r9_rise: assert property (@(posedge clk) disable iff (!rst_ni)
      ((lane_req & lane_en) != '0) |=> irq_o);
    a_r9_fall: assert property (@(posedge clk) disable iff (!rst_ni)
      ((lane_req & lane_en) == '0) |=> !irq_o);
  end else begin : g_comb
    assign irq_o = hit;
  end

  // R8: with transmit lane only and the selected source idle, no request
  a_r8_unselected: assert property (@(posedge clk) disable iff (!rst_ni)
    (mask_i[NUM_LANES-1:0] == 5'b00001 && !mask_i[EN_TXEOB] && !tx_src) |=>
      (!irq_o || !IRQ_REG));
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter bit IRQ_REG     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_rx_data,
  input  logic       ev_rx_overrun,
  input  logic       ev_rx_parity,
  input  logic       ev_rx_frame,
  input  logic       ev_rx_addr,
  input  logic       ev_rx_break,
  input  logic       ev_tx_buf_empty,
  input  logic       ev_tx_shift_empty,
  input  logic       ev_rx_eob,
  input  logic       ev_tx_eob,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       rx_dma_req,
  output logic       tx_dma_req
);
  logic             rst_sync_n;
  logic [REG_W-1:0] stat_set, stat_flags, mask_val;
  logic             wr_mask, wr_stat;

  sio_irq_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_mask = reg_wr & (reg_sel == SEL_MASK);
    wr_stat = reg_wr & (reg_sel == SEL_STAT);
    stat_set           = '0;
    stat_set[ST_TXBUF] = ev_tx_buf_empty;
    stat_set[ST_TXSHF] = ev_tx_shift_empty;
    stat_set[ST_RXDAT] = ev_rx_data;
    stat_set[ST_BRK]   = ev_rx_break;
    stat_set[ST_ADR]   = ev_rx_addr;
    stat_set[ST_OVR]   = ev_rx_overrun;
    stat_set[ST_PAR]   = ev_rx_parity;
    stat_set[ST_FRM]   = ev_rx_frame;
  end

  sio_irq_sticky #(.W(REG_W)) u_stat (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .set_i   (stat_set),
    .wr_i    (wr_stat),
    .wdata_i (reg_wdata),
    .flags_o (stat_flags)
  );

  sio_irq_maskreg u_mask (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .wr_i     (wr_mask),
    .wdata_i  (reg_wdata),
    .rx_eob_i (ev_rx_eob),
    .tx_eob_i (ev_tx_eob),
    .mask_o   (mask_val)
  );

  sio_irq_gate #(.IRQ_REG(IRQ_REG)) u_gate (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .mask_i   (mask_val),
    .stat_i   (stat_flags),
    .irq_o    (irq),
    .rx_dma_o (rx_dma_req),
    .tx_dma_o (tx_dma_req)
  );

  always_comb reg_rdata = (reg_sel == SEL_STAT) ? stat_flags : mask_val;

  // R10: receive DMA request ignores every enable bit
  a_r10_rx_dma: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_rx_data |=> rx_dma_req);
endmodule

// File: tb/sim_sio_irq_ctrl.sv
module sim_sio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [9:0] ev;
  logic       reg_wr, reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, rx_dma_req, tx_dma_req;

  always #2 clk = ~clk;

  sio_irq_ctrl #(.IRQ_REG(1'b1), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_buf_empty(ev[0]), .ev_tx_shift_empty(ev[1]), .ev_rx_data(ev[2]),
    .ev_rx_break(ev[3]), .ev_rx_addr(ev[4]), .ev_rx_overrun(ev[5]),
    .ev_rx_parity(ev[6]), .ev_rx_frame(ev[7]), .ev_rx_eob(ev[8]), .ev_tx_eob(ev[9]),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  typedef struct {
    string      tag;
    logic       irq;
    logic [7:0] rd;
    logic       rxd;
    logic       txd;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  logic [7:0] m_en, m_st;

  function automatic logic model_irq(input logic [7:0] m, input logic [7:0] s);
    logic tx;
    tx = m[7] ? s[0] : s[1];
    return (m[0] & (tx | m[5])) | (m[1] & (s[2] | m[6])) | (m[2] & s[3]) |
           (m[3] & s[4]) | (m[4] & (s[5] | s[6] | s[7]));
  endfunction

  task automatic step(input logic [9:0] e, input logic wr, input logic sel,
                      input logic [7:0] wd, input string tag);
    exp_t it;
    logic [7:0] keep;
    @(negedge clk);
    ev = e; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    #1;
    it.irq = model_irq(m_en, m_st);
    keep = (wr && sel) ? wd : 8'hFF;
    m_st = e[7:0] | (m_st & keep);
    keep = (wr && !sel) ? wd : 8'hFF;
    m_en[6] = e[8] | (m_en[6] & keep[6]);
    m_en[5] = e[9] | (m_en[5] & keep[5]);
    if (wr && !sel) begin
      m_en[7] = wd[7];
      m_en[4:0] = wd[4:0];
    end
    it.tag = tag;
    it.rd  = sel ? m_st : m_en;
    it.rxd = m_st[2];
    it.txd = m_en[7] ? m_st[0] : m_st[1];
    sb_q.push_back(it);
  endtask

  task automatic idle(input logic sel, input string tag);
    step(10'h000, 1'b0, sel, 8'h00, tag);
  endtask

  // monitor: pops expectations as results appear
  initial begin
    exp_t it;
    forever begin
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      checks++;
      if (irq !== it.irq) begin
        fails++;
        $display("FAIL %s irq actual=%0b expected=%0b", it.tag, irq, it.irq);
      end
      checks++;
      if (reg_rdata !== it.rd) begin
        fails++;
        $display("FAIL %s rdata actual=%02h expected=%02h", it.tag, reg_rdata, it.rd);
      end
      checks++;
      if (rx_dma_req !== it.rxd || tx_dma_req !== it.txd) begin
        fails++;
        $display("FAIL %s dma actual=%0b%0b expected=%0b%0b", it.tag,
                 rx_dma_req, tx_dma_req, it.rxd, it.txd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_en = 8'h00; m_st = 8'h00;
    ev = '0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1: reset state of both registers and outputs
    idle(1'b0, "R1");
    idle(1'b1, "R1");
    // R2 and R10: receive data sets a sticky flag, DMA sees it with enables clear
    step(10'h004, 1'b0, 1'b1, 8'h00, "R2");
    idle(1'b1, "R2");
    idle(1'b1, "R10");
    // R3: clear bit 2 only, then all flags, then upper half
    step(10'h000, 1'b1, 1'b1, 8'hFB, "R3");
    step(10'h0FF, 1'b0, 1'b1, 8'h00, "R2");
    step(10'h000, 1'b1, 1'b1, 8'h0F, "R3");
    idle(1'b1, "R3");
    step(10'h000, 1'b1, 1'b1, 8'h00, "R3");
    // R6: error lane
    step(10'h000, 1'b1, 1'b0, 8'h10, "R6");
    step(10'h020, 1'b0, 1'b0, 8'h00, "R6");
    idle(1'b0, "R6");
    idle(1'b0, "R9");
    step(10'h000, 1'b1, 1'b0, 8'h08, "R6");
    idle(1'b0, "R6");
    step(10'h010, 1'b0, 1'b1, 8'h00, "R6");
    idle(1'b1, "R9");
    step(10'h000, 1'b1, 1'b1, 8'h00, "R3");
    step(10'h000, 1'b1, 1'b0, 8'h04, "R6");
    step(10'h008, 1'b0, 1'b0, 8'h00, "R6");
    idle(1'b0, "R6");
    step(10'h000, 1'b1, 1'b1, 8'h00, "R3");
    idle(1'b0, "R9");
    // R7: receive end-of-block under receive enable
    step(10'h000, 1'b1, 1'b0, 8'h02, "R7");
    step(10'h100, 1'b0, 1'b0, 8'h00, "R7");
    idle(1'b0, "R7");
    // R4: writing 1 keeps the flag, writing 0 clears it
    step(10'h000, 1'b1, 1'b0, 8'h42, "R4");
    idle(1'b0, "R4");
    step(10'h000, 1'b1, 1'b0, 8'h02, "R4");
    idle(1'b0, "R4");
    // R5: pulse and clear in the same cycle
    step(10'h100, 1'b1, 1'b0, 8'h02, "R5");
    idle(1'b0, "R5");
    step(10'h004, 1'b1, 1'b1, 8'h00, "R5");
    idle(1'b1, "R5");
    step(10'h000, 1'b1, 1'b1, 8'h00, "R3");
    step(10'h000, 1'b1, 1'b0, 8'h00, "R4");
    idle(1'b0, "R7");
    // R8: shift source selected, buffer empty must not interrupt
    step(10'h000, 1'b1, 1'b0, 8'h01, "R8");
    step(10'h001, 1'b0, 1'b0, 8'h01, "R8");
    idle(1'b0, "R8");
    idle(1'b0, "R8");
    step(10'h000, 1'b1, 1'b0, 8'h81, "R8");
    idle(1'b0, "R8");
    step(10'h000, 1'b1, 1'b1, 8'h00, "R8");
    step(10'h002, 1'b0, 1'b1, 8'h00, "R8");
    idle(1'b1, "R8");
    step(10'h200, 1'b0, 1'b0, 8'h00, "R8");
    idle(1'b0, "R8");
    step(10'h000, 1'b1, 1'b0, 8'h80, "R10");
    idle(1'b0, "R9");
    idle(1'b0, "R9");
    wait (sb_q.size() == 0);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule